// File: doc/BRIEF.md
# Card Command Issue and Response Capture

This block launches a single card command each time software writes the command word with its enable bit set. It presents the 6-bit command index and the 32-bit argument to a card-side model over a level request, then gathers the bytes the card returns until the card signals completion. Once the command is complete, the block packs a valid response into four 32-bit response words or reports a command timeout. It emits exactly one single-cycle event pulse toward the status logic.

Software first writes the argument and then the command word. While a command is outstanding, further writes are ignored and the request stays stable. The block checks the response length against the response-expected and long-response bits of the command word. A length that is missing, wrong or unexpected is reported as a timeout, and so is an error signalled by the card. Interrupt-wait and pending modes are not supported: a command that asks for either is rejected at once as a timeout, and no request is issued.

Top module: `sdc_cmd_engine`

## Requirements
- R1: A write with `wr_sel`=1 whose bit 10 (enable) is set, and whose bits 8 and 9 are clear, starts a command. In the next cycle `req_valid` is high, `req_index` equals data bits 5:0 and `req_arg` equals the last written argument (`wr_sel`=0). All three hold until `rsp_done`.
- R2: A command write that has enable set together with bit 8 (interrupt-wait) or bit 9 (pending) issues no request. In the next cycle `ev_timeout` pulses, and the stored word keeps bits 8/9 with bit 10 cleared.
- R3: While `busy` is high, argument and command writes are ignored. While `busy` is low, `rsp_valid` and `rsp_done` are ignored.
- R4: Response bytes are packed big-endian: byte k lands in word k/4 at bits 31-8*(k mod 4):24-8*(k mod 4).
- R5: With response expected (bit 6) and long (bit 7) clear, exactly 4 bytes give `ev_resp_end`, fill `resp0` and force `resp1`..`resp3` to zero. A byte arriving in the same cycle as `rsp_done` is counted.
- R6: Exactly 16 bytes with response expected fill all four words and clear bit 0 of `resp3`, whether or not bit 7 is set.
- R7: With response expected, any other byte count (0, 8, more than 16), or 4 bytes with bit 7 set, gives `ev_timeout`.
- R8: `rsp_err` high with `rsp_done` gives `ev_timeout`, whatever the byte count and bit 6.
- R9: A command with bit 6 clear gives `ev_cmd_sent` when it completes without error, and any bytes returned for it are discarded.
- R10: In the cycle after `rsp_done`, `busy` and `req_valid` are low and bit 10 of `cmd_word` reads 0.
- R11: The response words change only together with `ev_resp_end`. Timeouts and no-response commands leave them unchanged.
- R12: Each completed or rejected command produces exactly one event, lasting one cycle. After reset all outputs read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: argument register, 1: command word |
| wr_data | input | 32 | Write data |
| cmd_word | output | 11 | Stored command word |
| arg_word | output | 32 | Stored argument |
| busy | output | 1 | Command outstanding |
| req_valid | output | 1 | Request to card, held until completion |
| req_index | output | 6 | Command index to card |
| req_arg | output | 32 | Command argument to card |
| rsp_valid | input | 1 | Response byte strobe from card |
| rsp_byte | input | 8 | Response byte |
| rsp_done | input | 1 | Card has finished the command |
| rsp_err | input | 1 | Card reports an error, qualified by rsp_done |
| resp0 | output | 32 | Response word 0 (first bytes) |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 (bit 0 cleared for 16 bytes) |
| ev_resp_end | output | 1 | Pulse: valid response captured |
| ev_cmd_sent | output | 1 | Pulse: no-response command finished |
| ev_timeout | output | 1 | Pulse: timeout, length error, card error or rejection |

## Verification
Two events can fall in the same cycle. The first is the card's last response byte arriving together with the completion strobe: the bench merges the final byte into the `rsp_done` cycle of a 4-byte response, and a success proves that the byte was counted before the length check. The second is a software command write landing in the very cycle the card completes: the bench issues that write alongside `rsp_done` and then checks that the stored index is still the old one and that no new request appears. Because `busy` is still high at that edge, the write is dropped.

// File: rtl/sdc_cmd_pkg.sv
`timescale 1ns/1ps
package sdc_cmd_pkg;
  localparam int CMD_W           = 11;
  localparam int IDX_W           = 6;
  localparam int ARG_W           = 32;
  localparam int RSP_MAX_BYTES   = 16;
  localparam int RSP_SHORT_BYTES = 4;
  localparam int RSP_WORDS       = RSP_MAX_BYTES / 4;
  localparam int CNT_W           = $clog2(RSP_MAX_BYTES + 2);
  localparam int POS_W           = $clog2(RSP_MAX_BYTES);

  // command word bit positions (decoded by software-visible layout)
  localparam int B_WANT  = 6;
  localparam int B_LONG  = 7;
  localparam int B_IWAIT = 8;
  localparam int B_PEND  = 9;
  localparam int B_EN    = 10;

  typedef logic [RSP_MAX_BYTES-1:0][7:0] rsp_bytes_t;
  typedef logic [RSP_WORDS-1:0][31:0]    rsp_words_t;
  typedef enum logic [1:0] {OUT_SENT, OUT_RESP, OUT_TMO} outcome_e;

  // big-endian packing: lowest byte index goes to the top of the word
  function automatic logic [31:0] pack_word(rsp_bytes_t b, int w);
    return {b[4*w], b[4*w+1], b[4*w+2], b[4*w+3]};
  endfunction

  function automatic logic len_ok(logic [CNT_W-1:0] n, logic long_req);
    return ((n == CNT_W'(RSP_SHORT_BYTES)) && !long_req) ||
           (n == CNT_W'(RSP_MAX_BYTES));
  endfunction

  function automatic outcome_e classify(logic err, logic want, logic long_req,
                                        logic [CNT_W-1:0] n);
    if (err)                   return OUT_TMO;
    else if (!want)            return OUT_SENT;
    else if (len_ok(n, long_req)) return OUT_RESP;
    else                       return OUT_TMO;
  endfunction
endpackage

// File: rtl/sdc_cmd_regs.sv
`timescale 1ns/1ps
module sdc_cmd_regs
  import sdc_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [ARG_W-1:0] wr_data,
  input  logic             cmd_done,
  output logic             start_o,
  output logic             reject_o,
  output logic             busy_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic [ARG_W-1:0] arg_o
);
  logic [CMD_W-1:0] cmd_q;
  logic [ARG_W-1:0] arg_q;
  logic             busy_q;
  logic             cmd_acc, arg_acc, en_req, mode_bad;

  assign cmd_acc  = wr_en &&  wr_sel && !busy_q;
  assign arg_acc  = wr_en && !wr_sel && !busy_q;
  assign en_req   = wr_data[B_EN];
  assign mode_bad = wr_data[B_IWAIT] | wr_data[B_PEND];
  assign start_o  = cmd_acc && en_req && !mode_bad;
  assign reject_o = cmd_acc && en_req &&  mode_bad;

  // enable survives in the stored word only while a command is in flight
  function automatic logic [CMD_W-1:0] stored_word(logic [CMD_W-1:0] w, logic go);
    logic [CMD_W-1:0] r;
    r       = w;
    r[B_EN] = go;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      arg_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (arg_acc) arg_q <= wr_data;
      if (cmd_acc)       cmd_q       <= stored_word(wr_data[CMD_W-1:0], start_o);
      else if (cmd_done) cmd_q[B_EN] <= 1'b0;
      if (start_o)       busy_q <= 1'b1;
      else if (cmd_done) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign cmd_o  = cmd_q;
  assign arg_o  = arg_q;

  assert_busy_arg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_en && !wr_sel) |=> $stable(arg_q));
  assert_busy_idx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_en && wr_sel) |=> $stable(cmd_q[IDX_W-1:0]));
  assert_reject_no_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |=> (!busy_q && !cmd_q[B_EN]));
endmodule

// File: rtl/sdc_rsp_collect.sv
`timescale 1ns/1ps
module sdc_rsp_collect
  import sdc_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic             rsp_valid,
  input  logic [7:0]       rsp_byte,
  output logic [CNT_W-1:0] cnt_now,
  output rsp_bytes_t       bytes_now
);
  logic [CNT_W-1:0] cnt_q;
  rsp_bytes_t       buf_q;
  logic             take;

  assign take = active && rsp_valid;

  // view including a byte arriving this cycle, so completion may coincide
  always_comb begin
    bytes_now = buf_q;
    cnt_now   = cnt_q;
    if (take && (cnt_q < CNT_W'(RSP_MAX_BYTES)))
      bytes_now[cnt_q[POS_W-1:0]] = rsp_byte;
    if (take && (cnt_q <= CNT_W'(RSP_MAX_BYTES)))
      cnt_now = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      buf_q <= '0;
    end else begin
      if (start) cnt_q <= '0;
      else       cnt_q <= cnt_now;
      buf_q <= bytes_now;
    end
  end

  assert_idle_bytes_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> $stable(cnt_q));
  assert_count_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cnt_q == CNT_W'(RSP_MAX_BYTES + 1)) |=> (cnt_q == CNT_W'(RSP_MAX_BYTES + 1)));
endmodule

// File: rtl/sdc_rsp_commit.sv
`timescale 1ns/1ps
module sdc_rsp_commit
  import sdc_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             reject,
  input  logic             want,
  input  logic             long_req,
  input  logic             err,
  input  logic [CNT_W-1:0] cnt_now,
  input  rsp_bytes_t       bytes_now,
  output rsp_words_t       resp_o,
  output logic             ev_resp_o,
  output logic             ev_sent_o,
  output logic             ev_tmo_o
);
  outcome_e   outcome;
  rsp_words_t new_words, resp_q;
  logic       full_len;
  logic       ev_resp_q, ev_sent_q, ev_tmo_q;

  assign outcome  = classify(err, want, long_req, cnt_now);
  assign full_len = (cnt_now == CNT_W'(RSP_MAX_BYTES));

  for (genvar w = 0; w < RSP_WORDS; w++) begin : g_word
    logic [31:0] word_w;
    always_comb begin
      if (full_len || w == 0) word_w = pack_word(bytes_now, w);
      else                    word_w = '0;
      if (w == RSP_WORDS - 1) word_w[0] = 1'b0;
    end
    assign new_words[w] = word_w;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_q    <= '0;
      ev_resp_q <= 1'b0;
      ev_sent_q <= 1'b0;
      ev_tmo_q  <= 1'b0;
    end else begin
      ev_resp_q <= 1'b0;
      ev_sent_q <= 1'b0;
      ev_tmo_q  <= 1'b0;
      if (reject) begin
        ev_tmo_q <= 1'b1;
      end else if (done) begin
        unique case (outcome)
          OUT_RESP: begin
            ev_resp_q <= 1'b1;
            resp_q    <= new_words;
          end
          OUT_SENT: ev_sent_q <= 1'b1;
          default:  ev_tmo_q  <= 1'b1;
        endcase
      end
    end
  end

  assign resp_o    = resp_q;
  assign ev_resp_o = ev_resp_q;
  assign ev_sent_o = ev_sent_q;
  assign ev_tmo_o  = ev_tmo_q;

  assert_one_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_resp_q, ev_sent_q, ev_tmo_q}));
  assert_last_bit_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resp_q |-> !resp_q[RSP_WORDS-1][0]);
  assert_resp_retained_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_resp_q |-> $stable(resp_q));
  assert_short_on_long_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && want && long_req && !err && cnt_now == CNT_W'(RSP_SHORT_BYTES)) |=> ev_tmo_q);
  assert_card_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |=> (ev_tmo_q && $stable(resp_q)));
  assert_short_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && want && !long_req && !err && cnt_now == CNT_W'(RSP_SHORT_BYTES))
    |=> (resp_q[1] == '0 && resp_q[2] == '0 && resp_q[3] == '0));
endmodule

// File: rtl/sdc_cmd_engine.sv
`timescale 1ns/1ps
module sdc_cmd_engine
  import sdc_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [ARG_W-1:0] wr_data,
  output logic [CMD_W-1:0] cmd_word,
  output logic [ARG_W-1:0] arg_word,
  output logic             busy,
  output logic             req_valid,
  output logic [IDX_W-1:0] req_index,
  output logic [ARG_W-1:0] req_arg,
  input  logic             rsp_valid,
  input  logic [7:0]       rsp_byte,
  input  logic             rsp_done,
  input  logic             rsp_err,
  output logic [31:0]      resp0,
  output logic [31:0]      resp1,
  output logic [31:0]      resp2,
  output logic [31:0]      resp3,
  output logic             ev_resp_end,
  output logic             ev_cmd_sent,
  output logic             ev_timeout
);
  logic             start_w, reject_w, busy_w, cmd_done_w;
  logic [CMD_W-1:0] cmd_w;
  logic [ARG_W-1:0] arg_w;
  logic [CNT_W-1:0] cnt_now_w;
  rsp_bytes_t       bytes_now_w;
  rsp_words_t       resp_w;

  assign cmd_done_w = busy_w && rsp_done;

  sdc_cmd_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .cmd_done (cmd_done_w),
    .start_o  (start_w),
    .reject_o (reject_w),
    .busy_o   (busy_w),
    .cmd_o    (cmd_w),
    .arg_o    (arg_w)
  );

  sdc_rsp_collect u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_w),
    .active    (busy_w),
    .rsp_valid (rsp_valid),
    .rsp_byte  (rsp_byte),
    .cnt_now   (cnt_now_w),
    .bytes_now (bytes_now_w)
  );

  sdc_rsp_commit u_commit (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (cmd_done_w),
    .reject    (reject_w),
    .want      (cmd_w[B_WANT]),
    .long_req  (cmd_w[B_LONG]),
    .err       (rsp_err),
    .cnt_now   (cnt_now_w),
    .bytes_now (bytes_now_w),
    .resp_o    (resp_w),
    .ev_resp_o (ev_resp_end),
    .ev_sent_o (ev_cmd_sent),
    .ev_tmo_o  (ev_timeout)
  );

  assign cmd_word  = cmd_w;
  assign arg_word  = arg_w;
  assign busy      = busy_w;
  assign req_valid = busy_w;
  assign req_index = cmd_w[IDX_W-1:0];
  assign req_arg   = arg_w;
  assign resp0     = resp_w[0];
  assign resp1     = resp_w[1];
  assign resp2     = resp_w[2];
  assign resp3     = resp_w[3];

  assert_req_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_done) |=> (req_valid && $stable(req_index) && $stable(req_arg)));
  assert_enable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_done) |=> (!cmd_word[B_EN] && !busy));
endmodule

// File: tb/tb_sdc_cmd_engine.sv
`timescale 1ns/1ps
module tb_sdc_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [10:0] cmd_word;
  logic [31:0] arg_word;
  logic        busy, req_valid;
  logic [5:0]  req_index;
  logic [31:0] req_arg;
  logic        rsp_valid = 1'b0, rsp_done = 1'b0, rsp_err = 1'b0;
  logic [7:0]  rsp_byte = '0;
  logic [31:0] resp0, resp1, resp2, resp3;
  logic        ev_resp_end, ev_cmd_sent, ev_timeout;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] exp_r [4];

  always #2.5 clk = ~clk;

  sdc_cmd_engine dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmd_word(cmd_word), .arg_word(arg_word), .busy(busy), .req_valid(req_valid),
    .req_index(req_index), .req_arg(req_arg), .rsp_valid(rsp_valid),
    .rsp_byte(rsp_byte), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .resp0(resp0), .resp1(resp1), .resp2(resp2), .resp3(resp3),
    .ev_resp_end(ev_resp_end), .ev_cmd_sent(ev_cmd_sent), .ev_timeout(ev_timeout)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bv(input logic [7:0] seed, input int k);
    return seed + 8'(k);
  endfunction

  function automatic logic [31:0] exp_word(input logic [7:0] seed, input int w);
    return {bv(seed, 4*w), bv(seed, 4*w+1), bv(seed, 4*w+2), bv(seed, 4*w+3)};
  endfunction

  task automatic check_resp(input string tag);
    chk({tag, " resp0"}, resp0, exp_r[0]);
    chk({tag, " resp1"}, resp1, exp_r[1]);
    chk({tag, " resp2"}, resp2, exp_r[2]);
    chk({tag, " resp3"}, resp3, exp_r[3]);
  endtask

  // flags = {en, pend, iwait, long, want}
  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [4:0] flags);
    @(negedge clk); wr_en = 1; wr_sel = 0; wr_data = arg;
    @(negedge clk); wr_sel = 1; wr_data = {21'b0, flags, idx};
    @(negedge clk); wr_en = 0; wr_sel = 0; wr_data = '0;
  endtask

  task automatic run_cmd(input string tag, input logic [5:0] idx, input logic [31:0] arg,
                         input bit want, input bit lng, input int n, input logic [7:0] seed,
                         input bit err, input bit merge);
    bit tmo, rsp, sent;
    issue(idx, arg, {1'b1, 2'b00, lng, want});
    chk({tag, " R1 req_valid"}, 32'(req_valid), 1);
    chk({tag, " R1 req_index"}, 32'(req_index), 32'(idx));
    chk({tag, " R1 req_arg"}, req_arg, arg);
    chk({tag, " R1 enable held"}, 32'(cmd_word[10]), 1);
    for (int i = 0; i < n; i++) begin
      rsp_valid = 1; rsp_byte = bv(seed, i);
      if (merge && i == n - 1) begin rsp_done = 1; rsp_err = err; end
      @(negedge clk);
    end
    rsp_valid = 0;
    if (!(merge && n > 0)) begin
      rsp_done = 1; rsp_err = err;
      @(negedge clk);
    end
    rsp_done = 0; rsp_err = 0;
    tmo  = err || (want && !((n == 4 && !lng) || n == 16));
    rsp  = !tmo && want;
    sent = !tmo && !want;
    if (rsp) begin
      exp_r[0] = exp_word(seed, 0);
      for (int w = 1; w < 4; w++) exp_r[w] = (n == 16) ? exp_word(seed, w) : 32'h0;
      exp_r[3][0] = 1'b0;
    end
    chk({tag, " R12 ev_resp_end"}, 32'(ev_resp_end), 32'(rsp));
    chk({tag, " R12 ev_cmd_sent"}, 32'(ev_cmd_sent), 32'(sent));
    chk({tag, " R12 ev_timeout"}, 32'(ev_timeout), 32'(tmo));
    chk({tag, " R10 busy"}, 32'(busy), 0);
    chk({tag, " R10 enable cleared"}, 32'(cmd_word[10]), 0);
    check_resp({tag, " R11"});
    @(negedge clk);
    chk({tag, " R12 pulse ends"}, 32'({ev_resp_end, ev_cmd_sent, ev_timeout}), 0);
  endtask

  task automatic t_reset();
    chk("R12 reset busy", 32'(busy), 0);
    chk("R12 reset cmd_word", 32'(cmd_word), 0);
    chk("R12 reset events", 32'({ev_resp_end, ev_cmd_sent, ev_timeout}), 0);
    check_resp("R12 reset");
  endtask

  task automatic t_idle_ignore();
    @(negedge clk); rsp_valid = 1; rsp_byte = 8'h77; rsp_done = 1;
    @(negedge clk); rsp_valid = 0; rsp_done = 0;
    chk("R3 idle done no event", 32'({ev_resp_end, ev_cmd_sent, ev_timeout}), 0);
    chk("R3 idle busy", 32'(busy), 0);
    check_resp("R3 idle");
  endtask

  task automatic t_reject(input logic [4:0] flags, input string tag);
    issue(6'd12, 32'h1234_5678, flags);
    chk({tag, " R2 timeout pulse"}, 32'(ev_timeout), 1);
    chk({tag, " R2 no request"}, 32'(req_valid), 0);
    chk({tag, " R2 enable cleared"}, 32'(cmd_word[10]), 0);
    chk({tag, " R2 mode bits kept"}, 32'(cmd_word[9:8]), 32'(flags[3:2]));
    @(negedge clk);
    chk({tag, " R2 pulse ends"}, 32'(ev_timeout), 0);
  endtask

  task automatic t_busy_write();
    issue(6'd5, 32'hAAAA_0005, 5'b10001);
    @(negedge clk); wr_en = 1; wr_sel = 0; wr_data = 32'hBBBB_BBBB;
    @(negedge clk); wr_sel = 1; wr_data = {21'b0, 5'b10001, 6'd9};
    @(negedge clk); wr_en = 0;
    chk("R3 busy arg kept", req_arg, 32'hAAAA_0005);
    chk("R3 busy index kept", 32'(req_index), 5);
    for (int i = 0; i < 4; i++) begin
      rsp_valid = 1; rsp_byte = bv(8'h10, i);
      if (i == 3) begin
        rsp_done = 1;
        wr_en = 1; wr_sel = 1; wr_data = {21'b0, 5'b10001, 6'd9};
      end
      @(negedge clk);
    end
    rsp_valid = 0; rsp_done = 0; wr_en = 0; wr_data = '0;
    exp_r[0] = exp_word(8'h10, 0); exp_r[1] = 0; exp_r[2] = 0; exp_r[3] = 0;
    chk("R3 write at done ignored index", 32'(cmd_word[5:0]), 5);
    chk("R3 write at done no busy", 32'(busy), 0);
    chk("R5 response with concurrent write", 32'(ev_resp_end), 1);
    check_resp("R4 busy case");
    @(negedge clk);
    chk("R3 no new request", 32'(req_valid), 0);
  endtask

  initial begin
    for (int w = 0; w < 4; w++) exp_r[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle_ignore();
    run_cmd("R5 short", 6'd17, 32'hCAFE_0001, 1, 0, 4, 8'hA0, 0, 0);
    run_cmd("R6 long", 6'd2, 32'h0000_0002, 1, 1, 16, 8'h32, 0, 0);
    run_cmd("R6 16 on short", 6'd9, 32'h0000_0009, 1, 0, 16, 8'h50, 0, 0);
    run_cmd("R7 4 on long", 6'd10, 32'h0000_000A, 1, 1, 4, 8'h60, 0, 0);
    run_cmd("R7 none", 6'd13, 32'h0000_000D, 1, 0, 0, 8'h00, 0, 0);
    run_cmd("R7 eight", 6'd14, 32'h0000_000E, 1, 0, 8, 8'h70, 0, 0);
    run_cmd("R7 over", 6'd15, 32'h0000_000F, 1, 1, 20, 8'h80, 0, 0);
    run_cmd("R8 err nores", 6'd0, 32'h0, 0, 0, 0, 8'h00, 1, 0);
    run_cmd("R8 err short", 6'd7, 32'h7, 1, 0, 4, 8'h90, 1, 0);
    run_cmd("R9 nores bytes", 6'd3, 32'h3, 0, 0, 4, 8'hB0, 0, 0);
    run_cmd("R5 merged last", 6'd18, 32'h18, 1, 0, 4, 8'hC4, 0, 1);
    t_reject(5'b10100, "iwait");
    t_reject(5'b11000, "pend");
    t_busy_write();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R10 act=%h exp=%h", 32'(busy), 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule